// File: doc/BRIEF.md
# Sticky GPIO Interrupt Status Register

This block holds an 8-bit status and interrupt register for five general-purpose pins. Each pin is set up by configuration inputs as a plain output, a live input, or a sticky input; one pin, chosen by a parameter, is given over to interrupt notification. Sticky inputs latch rising edges. A latched edge on a pin whose interrupt enable is set raises the register's interrupt flag and drives the notification pin high. Two further auxiliary flags are set by other logic and are cleared by the host.

The host writes and reads the register through a simple synchronous port. Flags and sticky bits clear only when a 0 is written to them, so writing a mask of ones with new output values changes outputs without disturbing pending events. When the host acknowledges an interrupt (it clears the interrupt flag) while another enabled sticky event is still latched, the notification pin drops low until one serial-clock tick has been seen and then rises again. This gives the host a fresh edge. With nothing pending the pin drops and stays low.

The notification logic is a three-state machine. `NTF_IDLE` holds the pin low and goes to `NTF_ASSERT` on an enabled event. `NTF_ASSERT` holds the pin high and, on an acknowledge, goes to `NTF_RENOTIFY` if an enabled event is still latched and to `NTF_IDLE` otherwise. `NTF_RENOTIFY` holds the pin low. It goes back to `NTF_ASSERT` on the next serial-clock tick, or to `NTF_IDLE` if an acknowledge leaves nothing pending.

Top module: `gpio_irq_status`

## Requirements
- R1: After a synchronous reset every stored bit reads 0, the notification pin is low, and only the notification pin has its output enable set.
- R2: Register layout: bit 7 is the interrupt flag (IRQF), bits 6 and 5 are auxiliary flags AUX1 and AUX0, and pin i (0..4) sits at bit 4-i. IRQF, AUX1 and AUX0 clear only when a 0 is written; writing 1 leaves them unchanged. A pulse on aux_set_i[j] sets AUXj.
- R3: A rising edge on a sticky input sets that pin's bit, and the bit stays 1 after the pin returns low.
- R4: A sticky pin's bit clears when a 0 is written to it; writing 1 has no effect.
- R5: For a pin configured as an output, its bit takes the written value and drives pin_o with pin_oe_o set.
- R6: For a non-sticky input, its bit reads the live pin level, and writes to it have no effect.
- R7: The notification pin's bit reads the notification pin level and cannot be written.
- R8: A sticky rising edge on a pin with its interrupt enable set sets IRQF and, from NTF_IDLE, drives the notification pin high on the next cycle. A sticky edge on a pin with the enable clear sets only its own bit.
- R9: Clearing IRQF while an enabled sticky bit remains set after the write drives the notification pin low, keeps IRQF at 1, and raises the pin again in the cycle after the first serial-clock tick.
- R10: Clearing IRQF with no enabled sticky bit left set drives the notification pin low, and it stays low while ticks arrive.
- R11: A new enabled event in the same cycle as a clearing write wins: its bit and IRQF are set after that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| scl_tick_i | input | 1 | One-cycle pulse per serial-clock period |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| dir_out_i | input | 5 | Per-pin direction, 1 = output |
| sticky_en_i | input | 5 | Per-pin sticky enable for inputs |
| irq_en_i | input | 5 | Per-pin interrupt enable |
| pin_i | input | 5 | Synchronized pin levels |
| aux_set_i | input | 2 | Set pulses for AUX1 and AUX0 |
| pin_o | output | 5 | Pin output values |
| pin_oe_o | output | 5 | Pin output enables |

## Verification
The assertions check on every cycle that sticky bits hold until a 0 is written and capture every rising edge. They also check that output bits follow writes, that IRQF ignores writes of 1 and sets on each enabled event, and that the machine moves from NTF_RENOTIFY to NTF_ASSERT on a tick and leaves NTF_ASSERT with the pin low on an acknowledge. Only the bench scenarios can show the register contents after all 256 write values have been applied to a preloaded state, and the exact cycles of the low re-notify pulse. They also cover the outcome when a write and a new event collide, and the live and interrupt-disabled pin behaviour as seen from the ports.

// File: rtl/gis_pkg.sv
package gis_pkg;

    typedef enum logic [1:0] {
        NTF_IDLE     = 2'd0,
        NTF_ASSERT   = 2'd1,
        NTF_RENOTIFY = 2'd2
    } ntf_state_t;

    typedef enum logic [1:0] {
        PM_OUT    = 2'd0,
        PM_STICKY = 2'd1,
        PM_LIVE   = 2'd2,
        PM_NOTIFY = 2'd3
    } pin_mode_t;

endpackage

// File: rtl/gis_edge_detect.sv
module gis_edge_detect #(
    parameter int W = 5
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);

    logic [W-1:0] lvl_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) lvl_q <= '0;
        else       lvl_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~lvl_q;

endmodule

// File: rtl/gis_pin_cell.sv
module gis_pin_cell
    import gis_pkg::*;
#(
    parameter bit IS_NOTIFY = 1'b0
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic dir_out_i,
    input  logic sticky_i,
    input  logic irq_en_i,
    input  logic pin_i,
    input  logic rise_i,
    input  logic wr_i,
    input  logic wr_bit_i,
    input  logic notify_lvl_i,
    output logic stat_o,
    output logic out_o,
    output logic oe_o,
    output logic evt_o,
    output logic pend_nxt_o
);

    pin_mode_t mode;
    logic      bit_q;
    logic      bit_d;
    logic      wr_clr;

    assign wr_clr = wr_i & ~wr_bit_i;

    generate
        if (IS_NOTIFY) begin : g_notify
            assign mode = PM_NOTIFY;
        end else begin : g_gpio
            always_comb begin
                if (dir_out_i)     mode = PM_OUT;
                else if (sticky_i) mode = PM_STICKY;
                else               mode = PM_LIVE;
            end
        end
    endgenerate

    always_comb begin
        unique case (mode)
            PM_OUT:    bit_d = wr_i ? wr_bit_i : bit_q;
            PM_STICKY: bit_d = (bit_q & ~wr_clr) | rise_i;
            PM_LIVE:   bit_d = pin_i;
            PM_NOTIFY: bit_d = 1'b0;
            default:   bit_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) bit_q <= 1'b0;
        else       bit_q <= bit_d;
    end

    always_comb begin
        unique case (mode)
            PM_OUT: begin
                stat_o = bit_q;
                out_o  = bit_q;
                oe_o   = 1'b1;
            end
            PM_STICKY: begin
                stat_o = bit_q;
                out_o  = 1'b0;
                oe_o   = 1'b0;
            end
            PM_LIVE: begin
                stat_o = pin_i;
                out_o  = 1'b0;
                oe_o   = 1'b0;
            end
            PM_NOTIFY: begin
                stat_o = notify_lvl_i;
                out_o  = notify_lvl_i;
                oe_o   = 1'b1;
            end
            default: begin
                stat_o = 1'b0;
                out_o  = 1'b0;
                oe_o   = 1'b0;
            end
        endcase
    end

    assign evt_o      = (mode == PM_STICKY) & irq_en_i & rise_i;
    assign pend_nxt_o = (mode == PM_STICKY) & irq_en_i & bit_d;

    // R3
    sticky_set_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode == PM_STICKY && rise_i) |=> bit_q);

    // R4
    sticky_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode == PM_STICKY && bit_q && !wr_clr) |=> bit_q);

    // R5
    out_write_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode == PM_OUT && wr_i) |=> (bit_q == $past(wr_bit_i)));

endmodule

// File: rtl/gis_notify_fsm.sv
module gis_notify_fsm
    import gis_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic evt_i,
    input  logic clr_int_i,
    input  logic pend_nxt_i,
    input  logic tick_i,
    output logic pin_o
);

    ntf_state_t st_q;
    ntf_state_t st_d;

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= NTF_IDLE;
        else       st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            NTF_IDLE: begin
                if (evt_i) st_d = NTF_ASSERT;
            end
            NTF_ASSERT: begin
                if (clr_int_i) st_d = pend_nxt_i ? NTF_RENOTIFY : NTF_IDLE;
            end
            NTF_RENOTIFY: begin
                if (clr_int_i && !pend_nxt_i) st_d = NTF_IDLE;
                else if (tick_i)              st_d = NTF_ASSERT;
            end
            default: st_d = NTF_IDLE;
        endcase
    end

    always_comb begin
        unique case (st_q)
            NTF_ASSERT: pin_o = 1'b1;
            default:    pin_o = 1'b0;
        endcase
    end

    // R8
    idle_raise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == NTF_IDLE && evt_i) |=> pin_o);

    // R9
    renotify_exit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == NTF_RENOTIFY && tick_i && !(clr_int_i && !pend_nxt_i)) |=> (st_q == NTF_ASSERT));

    // R10
    ack_drop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == NTF_ASSERT && clr_int_i) |=> !pin_o);

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status
    import gis_pkg::*;
#(
    parameter int N_PINS     = 5,
    parameter int N_AUX      = 2,
    parameter int NOTIFY_IDX = 4
) (
    input  logic                          clk_i,
    input  logic                          rst_i,
    input  logic                          scl_tick_i,
    input  logic                          wr_en_i,
    input  logic [N_PINS+N_AUX:0]         wr_data_i,
    output logic [N_PINS+N_AUX:0]         rd_data_o,
    input  logic [N_PINS-1:0]             dir_out_i,
    input  logic [N_PINS-1:0]             sticky_en_i,
    input  logic [N_PINS-1:0]             irq_en_i,
    input  logic [N_PINS-1:0]             pin_i,
    input  logic [N_AUX-1:0]              aux_set_i,
    output logic [N_PINS-1:0]             pin_o,
    output logic [N_PINS-1:0]             pin_oe_o
);

    localparam int REG_W   = 1 + N_AUX + N_PINS;
    localparam int INT_BIT = REG_W - 1;
    localparam int AUX_LO  = N_PINS;

    logic [N_PINS-1:0] rise;
    logic [N_PINS-1:0] evt;
    logic [N_PINS-1:0] pend_nxt;
    logic [N_PINS-1:0] gps_rd;
    logic [N_AUX-1:0]  aux_q;
    logic [N_AUX-1:0]  aux_clr;
    logic              int_q;
    logic              clr_int;
    logic              evt_any;
    logic              pend_any;
    logic              notify_lvl;

    gis_edge_detect #(.W(N_PINS)) edge_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .lvl_i  (pin_i),
        .rise_o (rise)
    );

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        gis_pin_cell #(.IS_NOTIFY(i == NOTIFY_IDX)) cell_i (
            .clk_i        (clk_i),
            .rst_i        (rst_i),
            .dir_out_i    (dir_out_i[i]),
            .sticky_i     (sticky_en_i[i]),
            .irq_en_i     (irq_en_i[i]),
            .pin_i        (pin_i[i]),
            .rise_i       (rise[i]),
            .wr_i         (wr_en_i),
            .wr_bit_i     (wr_data_i[N_PINS-1-i]),
            .notify_lvl_i (notify_lvl),
            .stat_o       (gps_rd[N_PINS-1-i]),
            .out_o        (pin_o[i]),
            .oe_o         (pin_oe_o[i]),
            .evt_o        (evt[i]),
            .pend_nxt_o   (pend_nxt[i])
        );
    end

    assign evt_any  = |evt;
    assign pend_any = |pend_nxt;
    assign clr_int  = wr_en_i & ~wr_data_i[INT_BIT];
    assign aux_clr  = wr_en_i ? ~wr_data_i[AUX_LO +: N_AUX] : '0;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            int_q <= 1'b0;
            aux_q <= '0;
        end else begin
            int_q <= evt_any | (clr_int & pend_any) | (int_q & ~clr_int);
            aux_q <= (aux_q & ~aux_clr) | aux_set_i;
        end
    end

    gis_notify_fsm fsm_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .evt_i      (evt_any),
        .clr_int_i  (clr_int),
        .pend_nxt_i (pend_any),
        .tick_i     (scl_tick_i),
        .pin_o      (notify_lvl)
    );

    assign rd_data_o = {int_q, aux_q, gps_rd};

    // R8
    int_set_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        evt_any |=> int_q);

    // R2
    int_w1_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (int_q && wr_en_i && wr_data_i[INT_BIT]) |=> int_q);

    // R2
    aux_w1_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && (&wr_data_i[AUX_LO +: N_AUX])) |=> ((aux_q & $past(aux_q)) == $past(aux_q)));

    // R7
    notify_oe_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        pin_oe_o[NOTIFY_IDX] && (pin_o[NOTIFY_IDX] == rd_data_o[N_PINS-1-NOTIFY_IDX]));

endmodule

// File: tb/gpio_irq_status_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_status_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic [4:0] dir_out;
    logic [4:0] sticky;
    logic [4:0] irq_en;
    logic [4:0] pin_in;
    logic [1:0] aux_set;
    logic [4:0] pin_out;
    logic [4:0] pin_oe;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    gpio_irq_status dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .scl_tick_i  (tick),
        .wr_en_i     (wr_en),
        .wr_data_i   (wr_data),
        .rd_data_o   (rd_data),
        .dir_out_i   (dir_out),
        .sticky_en_i (sticky),
        .irq_en_i    (irq_en),
        .pin_i       (pin_in),
        .aux_set_i   (aux_set),
        .pin_o       (pin_out),
        .pin_oe_o    (pin_oe)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        wr_en   = 1'b0;
        wr_data = 8'h00;
        tick    = 1'b0;
        aux_set = 2'b00;
    endtask

    task automatic write(input logic [7:0] v);
        wr_en   = 1'b1;
        wr_data = v;
        step();
        wr_en   = 1'b0;
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst     = 1'b1;
        dir_out = 5'b00000;
        sticky  = 5'b00000;
        irq_en  = 5'b00000;
        pin_in  = 5'b00000;
        @(negedge clk);
        step();
        step();
        rst = 1'b0;
        step();

        // R1 reset state
        chk("R1 rd", rd_data, 8'h00);
        chk("R1 pin_o", {3'b0, pin_out}, 8'h00);
        chk("R1 oe", {3'b0, pin_oe}, 8'h10);

        // R6 live input reads pin, writes ignored
        sticky = 5'b00011;
        pin_in[2] = 1'b1;
        #1;
        chk("R6 live high", {7'b0, rd_data[2]}, 8'h01);
        @(negedge clk);
        write(8'h00);
        chk("R6 write ignored", {7'b0, rd_data[2]}, 8'h01);
        chk("R6 no irq", {7'b0, rd_data[7]}, 8'h00);
        pin_in[2] = 1'b0;
        #1;
        chk("R6 live low", {7'b0, rd_data[2]}, 8'h00);
        @(negedge clk);

        // R8 sticky without interrupt enable
        dir_out = 5'b01100;
        irq_en  = 5'b00001;
        write(8'h00);
        pin_in = 5'b00010;
        step();
        pin_in = 5'b00000;
        step();
        chk("R8 disabled sticky only", rd_data, 8'h08);
        chk("R8 disabled no notify", {7'b0, pin_out[4]}, 8'h00);

        // R7 notify bit not writable
        write(8'h00);
        write(8'h01);
        chk("R7 notify bit", {7'b0, rd_data[0]}, 8'h00);
        chk("R7 notify pin", {7'b0, pin_out[4]}, 8'h00);
        chk("R5 oe", {3'b0, pin_oe}, 8'h1C);

        // Sweep all write values over a preloaded state
        irq_en = 5'b00011;
        for (int v = 0; v < 256; v++) begin
            logic [7:0] vv;
            logic       pend;
            logic [7:0] exp;
            vv = v[7:0];
            write(8'h00);
            pin_in  = 5'b00011;
            aux_set = 2'b11;
            step();
            pin_in  = 5'b00000;
            aux_set = 2'b00;
            step();
            // R3 captured and held after pin low; R8 notify high
            chk("R3 R8 preload", rd_data, 8'hF9);
            write(vv);
            pend = vv[4] | vv[3];
            exp  = {vv[7] | pend, vv[6], vv[5], vv[4], vv[3], vv[2], vv[1], vv[7]};
            // R2 R4 R5 R9 R10 register after write
            chk($sformatf("R2 R4 R5 R9 R10 rd v=%h", vv), rd_data, exp);
            chk($sformatf("R5 pins v=%h", vv), {3'b0, pin_out}, {3'b0, vv[7], vv[1], vv[2], 2'b00});
            tick = 1'b1;
            step();
            tick = 1'b0;
            chk($sformatf("R9 R10 after tick v=%h", vv), {7'b0, pin_out[4]}, {7'b0, vv[7] | pend});
        end

        // R11 set wins over clearing write
        write(8'h00);
        pin_in = 5'b00001;
        step();
        pin_in = 5'b00000;
        step();
        wr_en   = 1'b1;
        wr_data = 8'h00;
        pin_in  = 5'b00010;
        step();
        wr_en  = 1'b0;
        pin_in = 5'b00000;
        chk("R11 set wins", rd_data, 8'h88);
        tick = 1'b1;
        step();
        tick = 1'b0;
        chk("R11 renotify high", {7'b0, pin_out[4]}, 8'h01);

        // R9 pulse held low until a tick
        pin_in = 5'b00001;
        step();
        pin_in = 5'b00000;
        step();
        write(8'h77);
        chk("R9 ack with pending", rd_data, 8'h96);
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R9 low without tick", {7'b0, pin_out[4]}, 8'h00);
        end
        tick = 1'b1;
        step();
        tick = 1'b0;
        chk("R9 high after tick", {7'b0, pin_out[4]}, 8'h01);

        // R10 nothing pending: stays low through ticks
        write(8'h00);
        chk("R10 cleared", rd_data, 8'h00);
        tick = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R10 stays low", {7'b0, pin_out[4]}, 8'h00);
        end
        tick = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule